// File: doc/BRIEF.md
# Dual-Half HDLC Receive Buffer

This block sits between the byte output of an HDLC receiver and a host read port. It stores up to 64 bytes, and it hands them to the host in windows of at most one half, 32 bytes. The receiver passes the bytes of each frame starting at the control field, because the address is consumed upstream. It marks the trailing status byte of each frame with an end flag. A frame is therefore at least two bytes long.

Incoming bytes are cut into segments. A segment ends when a frame's status byte arrives or when 32 bytes of a still-open frame have been collected. Each finished segment is held behind the visible one in a queue of up to 16 entries. When nothing is visible, the oldest queued segment is shown to the host. The block raises either a block-ready request (a 32-byte piece of a longer frame) or an end-of-message request (a frame tail, 1 to 32 bytes), together with the byte count. The host reads the window byte by byte and then acknowledges. The acknowledge frees the window and, one cycle later, brings up the next queued segment with no further input from the receiver.

The store is a 64-byte ring. Bytes that find no room, or that would close a segment while the queue is full, are dropped and latch an overflow flag. A synchronous flush command empties everything and clears that flag.

Top module: `rxbuf_dual_half`

## Requirements
- R1: The store holds at most 64 bytes, counting the visible window, the queued segments and any open segment. A byte written while 64 bytes are held is discarded and sets `ovf`, which stays set until `flush`.
- R2: A byte written with `wr_eof`=1 closes a segment that includes that byte, 1 to 32 bytes long. When that segment is shown, `eom_req`=1, `blk_req`=0 and `rd_count` equals its length. A segment is shown on the second rising edge after its closing byte when nothing was visible.
- R3: When 32 bytes of a frame have been stored without an end flag, those 32 bytes form a segment. When it is shown, `blk_req`=1, `eom_req`=0 and `rd_count`=32.
- R4: An `ack` while a window is visible clears `rd_count`, `eom_req` and `blk_req` at the next edge and frees those bytes. At the following edge the next queued segment, if any, is shown.
- R5: Up to 16 closed segments wait behind the visible one and are shown in arrival order, so 17 short frames can be held at once.
- R6: A byte that would close a segment while 16 segments are already queued, and no segment is being taken from the queue in that cycle, is discarded and sets `ovf`.
- R7: `rd_data` shows the window byte at the read offset, which is 0 when a window is shown. Each `rd_strobe` advances the offset by one, up to the last byte of the window. Further strobes leave `rd_data` on the last byte.
- R8: An `ack` while no window is visible has no effect: the count stays 0 and later frames are shown normally.
- R9: A `flush` pulse empties the store, clears the segment queue, both requests, the count and `ovf` at the next edge. The next frame is then shown from its own first byte.
- R10: After reset `rd_count`=0, `eom_req`=0, `blk_req`=0, `ovf`=0 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_valid | input | 1 | Receiver byte strobe |
| wr_data | input | 8 | Receiver byte |
| wr_eof | input | 1 | Byte is the frame's trailing status byte |
| rd_strobe | input | 1 | Host read strobe, advances the read offset |
| rd_data | output | 8 | Byte at the current read offset, 0 when nothing is visible |
| rd_count | output | 6 | Byte count of the visible window, 0 when none |
| ack | input | 1 | Host acknowledge, releases the visible window |
| flush | input | 1 | Synchronous empty and overflow clear |
| blk_req | output | 1 | Visible window is a 32-byte block of an open frame |
| eom_req | output | 1 | Visible window ends a frame |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The hardest situation to reach is a full segment queue. The bench gets there by writing seventeen two-byte frames without any acknowledge: the first frame is shown and the other sixteen fill the queue. It then writes an eighteenth frame, whose status byte must be dropped. After that, acknowledges alone must walk through the sixteen waiting frames in order. Ring exhaustion is reached separately by streaming a long frame with no end flag while the host holds back, so that the 65th byte meets a full store.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Kind of a segment held in the marker queue or shown to the host.
  typedef enum logic {
    SEG_BLOCK = 1'b0,   // 32-byte piece of a frame still open
    SEG_END   = 1'b1    // closing piece of a frame, status byte last
  } seg_kind_e;

endpackage

// File: rtl/rxq_rst_sync.sv
module rxq_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          we,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp_q, wp_n;

  always_comb begin
    wp_n = wp_q;
    if (flush)   wp_n = '0;
    else if (we) wp_n = wp_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wp_q <= '0;
    else        wp_q <= wp_n;
  end

  // Storage array: write enable only, no reset.
  always_ff @(posedge clk) begin
    if (we) mem[wp_q] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/rxq_mark_fifo.sv
module rxq_mark_fifo #(
  parameter  int DEPTH = 16,
  parameter  int W     = 7,
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);

  logic [W-1:0]  ent_q [DEPTH];
  logic [PW-1:0] wptr_q, wptr_n, rptr_q, rptr_n;
  logic [CW-1:0] cnt_q, cnt_n;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (push && wptr_q == PW'(i)) ent_q[i] <= din;
    end
  end

  always_comb begin
    wptr_n = wptr_q;
    rptr_n = rptr_q;
    cnt_n  = cnt_q;
    if (flush) begin
      wptr_n = '0;
      rptr_n = '0;
      cnt_n  = '0;
    end else begin
      if (push) wptr_n = wptr_q + PW'(1);
      if (pop)  rptr_n = rptr_q + PW'(1);
      cnt_n = cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      cnt_q  <= cnt_n;
    end
  end

  assign head  = ent_q[rptr_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));

  AST_Q_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    push && !flush |-> !full || pop);                                    // R6
  AST_Q_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);                                                     // R5
  AST_Q_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));                                                // R5

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter  int HALF  = 32,
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = $clog2(HALF + 1),
  localparam int OFW   = $clog2(HALF),
  localparam int OW    = $clog2(DEPTH + 1),
  localparam int MW    = LW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic          wr_eof,
  input  logic          ack,
  input  logic          flush,
  input  logic          rd_strobe,
  input  logic          q_empty,
  input  logic          q_full,
  input  logic [MW-1:0] q_head,
  output logic          accept,
  output logic          push,
  output logic [MW-1:0] push_word,
  output logic          pop,
  output logic [AW-1:0] raddr,
  output logic [LW-1:0] vlen,
  output logic          eom_req,
  output logic          blk_req,
  output logic          ovf
);

  logic [OW-1:0]  occ_q,  occ_n;
  logic [AW-1:0]  base_q, base_n;
  logic [LW-1:0]  vlen_q, vlen_n;
  logic [OFW-1:0] rofs_q, rofs_n;
  logic [OFW-1:0] seg_q,  seg_n;
  seg_kind_e      kind_q, kind_n;
  logic           ovf_q,  ovf_n;
  logic           ack_eff, closes, vis;

  assign vis     = (vlen_q != '0);
  assign ack_eff = ack & vis;
  assign pop     = ~flush & ~vis & ~q_empty;
  assign closes  = wr_eof | (seg_q == OFW'(HALF - 1));
  assign accept  = wr_valid & ~flush & (occ_q != OW'(DEPTH))
                 & ~(closes & q_full & ~pop);
  assign push    = accept & closes;
  assign push_word = {wr_eof, LW'(seg_q) + LW'(1)};

  always_comb begin
    occ_n  = occ_q;
    base_n = base_q;
    vlen_n = vlen_q;
    rofs_n = rofs_q;
    seg_n  = seg_q;
    kind_n = kind_q;
    ovf_n  = ovf_q;
    if (flush) begin
      occ_n  = '0;
      base_n = '0;
      vlen_n = '0;
      rofs_n = '0;
      seg_n  = '0;
      kind_n = SEG_BLOCK;
      ovf_n  = 1'b0;
    end else begin
      occ_n = occ_q + OW'(accept) - (ack_eff ? OW'(vlen_q) : OW'(0));
      if (accept)              seg_n = closes ? '0 : seg_q + OFW'(1);
      if (wr_valid && !accept) ovf_n = 1'b1;
      if (ack_eff) begin
        base_n = base_q + AW'(vlen_q);
        vlen_n = '0;
        rofs_n = '0;
      end else if (pop) begin
        vlen_n = q_head[LW-1:0];
        kind_n = seg_kind_e'(q_head[MW-1]);
        rofs_n = '0;
      end else if (rd_strobe && vis && (LW'(rofs_q) + LW'(1) < vlen_q)) begin
        rofs_n = rofs_q + OFW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q  <= '0;
      base_q <= '0;
      vlen_q <= '0;
      rofs_q <= '0;
      seg_q  <= '0;
      kind_q <= SEG_BLOCK;
      ovf_q  <= 1'b0;
    end else begin
      occ_q  <= occ_n;
      base_q <= base_n;
      vlen_q <= vlen_n;
      rofs_q <= rofs_n;
      seg_q  <= seg_n;
      kind_q <= kind_n;
      ovf_q  <= ovf_n;
    end
  end

  assign raddr   = base_q + AW'(rofs_q);
  assign vlen    = vlen_q;
  assign eom_req = vis & (kind_q == SEG_END);
  assign blk_req = vis & (kind_q == SEG_BLOCK);
  assign ovf     = ovf_q;

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OW'(DEPTH));                                                // R1
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !flush && occ_q == OW'(DEPTH) |=> ovf_q);                // R1
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !flush |=> ovf_q);                                          // R1
  AST_VIS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    vlen_q <= LW'(HALF));                                                // R2
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(eom_req && blk_req));                                              // R3
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ack && vis |=> vlen_q == '0 && !eom_req && !blk_req);                // R4
  AST_RD_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    vis |-> LW'(rofs_q) < vlen_q);                                       // R7
  AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !vis && !flush |=> $stable(base_q));                          // R8
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> occ_q == '0 && vlen_q == '0 && !ovf_q);                    // R9

endmodule

// File: rtl/rxbuf_dual_half.sv
module rxbuf_dual_half #(
  parameter  int HALF_BYTES = 32,
  parameter  int NUM_HALVES = 2,
  parameter  int MARK_DEPTH = 16,
  localparam int DEPTH      = HALF_BYTES * NUM_HALVES,
  localparam int AW         = $clog2(DEPTH),
  localparam int LW         = $clog2(HALF_BYTES + 1),
  localparam int MW         = LW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [7:0]    wr_data,
  input  logic          wr_eof,
  input  logic          rd_strobe,
  output logic [7:0]    rd_data,
  output logic [LW-1:0] rd_count,
  input  logic          ack,
  input  logic          flush,
  output logic          blk_req,
  output logic          eom_req,
  output logic          ovf
);

  logic          rst_n_s;
  logic          accept, push, pop, q_empty, q_full;
  logic [MW-1:0] push_word, q_head;
  logic [AW-1:0] raddr;
  logic [7:0]    store_rdata;

  rxq_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n_s),
    .flush (flush),
    .we    (accept),
    .wdata (wr_data),
    .raddr (raddr),
    .rdata (store_rdata)
  );

  rxq_mark_fifo #(.DEPTH(MARK_DEPTH), .W(MW)) u_marks (
    .clk   (clk),
    .rst_n (rst_n_s),
    .flush (flush),
    .push  (push),
    .pop   (pop),
    .din   (push_word),
    .head  (q_head),
    .empty (q_empty),
    .full  (q_full)
  );

  rxq_ctrl #(.HALF(HALF_BYTES), .DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_valid  (wr_valid),
    .wr_eof    (wr_eof),
    .ack       (ack),
    .flush     (flush),
    .rd_strobe (rd_strobe),
    .q_empty   (q_empty),
    .q_full    (q_full),
    .q_head    (q_head),
    .accept    (accept),
    .push      (push),
    .push_word (push_word),
    .pop       (pop),
    .raddr     (raddr),
    .vlen      (rd_count),
    .eom_req   (eom_req),
    .blk_req   (blk_req),
    .ovf       (ovf)
  );

  assign rd_data = (rd_count != '0) ? store_rdata : 8'h00;

endmodule

// File: tb/rxbuf_dual_half_tb_top.sv
`timescale 1ns/1ps
module rxbuf_dual_half_tb_top;

  logic       clk = 1'b0;
  logic       rst_n, wr_valid, wr_eof, rd_strobe, ack, flush;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic [5:0] rd_count;
  logic       blk_req, eom_req, ovf;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  rxbuf_dual_half dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_eof(wr_eof), .rd_strobe(rd_strobe), .rd_data(rd_data),
    .rd_count(rd_count), .ack(ack), .flush(flush), .blk_req(blk_req),
    .eom_req(eom_req), .ovf(ovf)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic wr(input logic [7:0] d, input logic e);
    wr_valid = 1'b1; wr_data = d; wr_eof = e;
    @(negedge clk);
    wr_valid = 1'b0; wr_eof = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  task automatic pulse_rd();
    rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
  endtask

  task automatic pulse_flush();
    flush = 1'b1; @(negedge clk); flush = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 count", rd_count, 0);
    chk("R10 eom", eom_req, 0);
    chk("R10 blk", blk_req, 0);
    chk("R10 ovf", ovf, 0);
    chk("R10 data", rd_data, 0);
  endtask

  task automatic t_single_frame();
    logic [7:0] fr [4];
    fr = '{8'hA1, 8'hA2, 8'hA3, 8'h5C};
    for (int k = 0; k < 4; k++) wr(fr[k], k == 3);
    chk("R2 not yet shown", rd_count, 0);
    @(negedge clk);
    chk("R2 eom", eom_req, 1);
    chk("R2 blk low", blk_req, 0);
    chk("R2 count", rd_count, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R7 byte", rd_data, fr[k]);
      pulse_rd();
    end
    chk("R7 hold last", rd_data, 8'h5C);
    pulse_rd();
    chk("R7 hold last again", rd_data, 8'h5C);
    pulse_ack();
    chk("R4 count cleared", rd_count, 0);
    chk("R4 eom cleared", eom_req, 0);
    @(negedge clk);
    chk("R4 nothing queued", rd_count, 0);
  endtask

  task automatic t_idle_ack();
    pulse_ack();
    @(negedge clk);
    chk("R8 count", rd_count, 0);
    chk("R8 ovf", ovf, 0);
    wr(8'h31, 1'b0);
    wr(8'h32, 1'b1);
    @(negedge clk);
    chk("R8 frame shown", eom_req, 1);
    chk("R8 frame count", rd_count, 2);
    chk("R8 frame data", rd_data, 8'h31);
    pulse_ack();
    @(negedge clk);
  endtask

  task automatic t_queue_full();
    for (int i = 0; i < 17; i++) begin
      wr(8'h10 + 8'(i), 1'b0);
      wr(8'h80 + 8'(i), 1'b1);
    end
    @(negedge clk);
    chk("R5 first eom", eom_req, 1);
    chk("R5 first count", rd_count, 2);
    chk("R5 first data", rd_data, 8'h10);
    chk("R6 no ovf at 17", ovf, 0);
    wr(8'h70, 1'b0);
    wr(8'h71, 1'b1);
    @(negedge clk);
    chk("R6 ovf on 18th", ovf, 1);
    chk("R6 visible kept", rd_data, 8'h10);
    for (int i = 1; i < 17; i++) begin
      pulse_ack();
      chk("R4 gap", eom_req, 0);
      @(negedge clk);
      chk("R5 queued eom", eom_req, 1);
      chk("R5 queued count", rd_count, 2);
      chk("R5 queued order", rd_data, 8'h10 + i);
    end
    pulse_ack();
    @(negedge clk);
    chk("R6 dropped frame not shown", rd_count, 0);
    pulse_flush();
    chk("R9 ovf cleared", ovf, 0);
    chk("R9 count", rd_count, 0);
    chk("R9 eom", eom_req, 0);
  endtask

  task automatic t_long_frame();
    for (int i = 0; i < 70; i++) wr(8'(i), 1'b0);
    chk("R3 blk", blk_req, 1);
    chk("R3 eom low", eom_req, 0);
    chk("R3 count", rd_count, 32);
    chk("R3 first data", rd_data, 0);
    chk("R1 ovf", ovf, 1);
    pulse_rd();
    chk("R7 advance", rd_data, 1);
    pulse_ack();
    @(negedge clk);
    chk("R3 second blk", blk_req, 1);
    chk("R3 second count", rd_count, 32);
    chk("R1 second data", rd_data, 32);
    for (int k = 0; k < 31; k++) pulse_rd();
    chk("R1 last kept byte", rd_data, 63);
    wr(8'hEE, 1'b1);
    pulse_ack();
    @(negedge clk);
    chk("R2 tail eom", eom_req, 1);
    chk("R2 tail count 1", rd_count, 1);
    chk("R2 tail data", rd_data, 8'hEE);
    chk("R1 ovf sticky", ovf, 1);
    pulse_ack();
    @(negedge clk);
  endtask

  task automatic t_flush();
    wr(8'h44, 1'b0);
    wr(8'h45, 1'b1);
    wr(8'h46, 1'b0);
    wr(8'h47, 1'b1);
    pulse_flush();
    chk("R9 count", rd_count, 0);
    chk("R9 eom", eom_req, 0);
    chk("R9 ovf", ovf, 0);
    @(negedge clk);
    chk("R9 queue empty", rd_count, 0);
    wr(8'h99, 1'b0);
    wr(8'h9A, 1'b1);
    @(negedge clk);
    chk("R9 new frame count", rd_count, 2);
    chk("R9 new frame data", rd_data, 8'h99);
  endtask

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_eof = 1'b0; wr_data = 8'h00;
    rd_strobe = 1'b0; ack = 1'b0; flush = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_single_frame();
    t_idle_ack();
    t_queue_full();
    t_long_frame();
    t_flush();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule